// File: doc/BRIEF.md
# Conversion Sample Queue with Threshold Request

This block holds converter results until software or a DMA engine drains them. Each completed conversion arrives as a one-cycle valid pulse. The pulse carries a 12-bit value and an error bit. When queueing is enabled, the result is formatted and stored. A read strobe pops the oldest entry and returns it as a 16-bit word. An optional shift mode reduces each value to a byte so that it suits byte-wide DMA buffers. When error capture is on, the error bit stays at bit 15 in both the full-width and the shifted formats.

The block reports its fill level and its full and empty state. It also keeps sticky overflow and underflow flags, and a write of 1 clears each flag. A programmable threshold drives both a DMA request and an interrupt. The interrupt has raw, enable, force and masked views. Configuration comes from write strobes supplied by a bus decoder outside this block.

Top module: `sample_queue`

## Requirements
- R1: When the queue enable input is 0, a valid pulse stores nothing and the level does not change. When it is 1, each valid pulse stores exactly one entry.
- R2: Entries leave in the order they arrived. A read strobe on a non-empty queue returns the oldest entry and lowers the level by one.
- R3: In shift mode the stored value is the 12-bit value shifted right by 4, which places bits 11:4 in bits 7:0 of the read word. Outside shift mode the value occupies bits 11:0.
- R4: When error capture is on, bit 15 of the read word holds the sample's error bit in both formats. When error capture is off, bit 15 is 0. Bits 14:12, and bits 14:8 in shift mode, always read 0.
- R5: The depth is 4 entries. The level output counts the stored entries. The full output is 1 exactly when the level is 4, and the empty output is 1 exactly when the level is 0.
- R6: A valid pulse while full discards the new sample and sets the sticky overflow flag. A simultaneous valid pulse and read strobe while full is accepted without overflow, and the level stays at 4.
- R7: A read strobe while empty returns 0 and sets the sticky underflow flag.
- R8: A flag clear strobe with bit 1 set clears overflow, and one with bit 0 set clears underflow. A flag that is not selected keeps its value.
- R9: The raw interrupt is 1 when the level is greater than or equal to the 4-bit threshold. The DMA request equals the raw interrupt ANDed with the request enable.
- R10: The interrupt output is the raw interrupt ANDed with the interrupt enable, then ORed with the force bit.
- R11: After reset the level is 0, empty is 1, full is 0, both flags are 0 and all configuration is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | Conversion result valid pulse |
| res_val_i | input | 12 | Conversion value |
| res_err_i | input | 1 | Conversion error bit |
| cfg_we_i | input | 1 | Write strobe for the config word |
| cfg_wdata_i | input | 4 | Config bits: {req_en, err_en, shift_en, q_en} |
| thr_we_i | input | 1 | Write strobe for the threshold |
| thr_wdata_i | input | 4 | Threshold value |
| int_we_i | input | 1 | Write strobe for the interrupt controls |
| int_wdata_i | input | 2 | Interrupt controls: {force, enable} |
| flag_clr_i | input | 1 | Strobe that clears the selected flags |
| flag_clr_mask_i | input | 2 | Flags to clear: {overflow, underflow} |
| rd_i | input | 1 | Read strobe that pops one entry |
| rd_data_o | output | 16 | Read word, valid in the cycle of the read strobe |
| level_o | output | 3 | Number of stored entries |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| over_o | output | 1 | Sticky overflow flag |
| under_o | output | 1 | Sticky underflow flag |
| dreq_o | output | 1 | DMA request |
| irq_raw_o | output | 1 | Raw interrupt (level >= threshold) |
| irq_o | output | 1 | Masked and forced interrupt |

## Verification
The hardest case to reach from the ports is a valid pulse and a read strobe in the same cycle while the queue is full. The bench fills the queue to four entries, then pulses both strobes together. It checks that overflow stays clear, that the level stays at 4 and that the entries remain in order. The bench also sweeps every threshold value against every fill level, with the request and interrupt bits in all combinations. It sends value patterns in both formats, with error capture on and off.

// File: rtl/sample_queue_pkg.sv
package sample_queue_pkg;
  parameter int VAL_W  = 12;
  parameter int WORD_W = 16;
  parameter int DEPTH  = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  typedef struct packed {
    logic req_en;
    logic err_en;
    logic shift_en;
    logic q_en;
  } cfg_t;
endpackage

// File: rtl/sq_format.sv
module sq_format
  import sample_queue_pkg::*;
(
  input  logic [VAL_W-1:0]  val_i,
  input  logic              err_i,
  input  logic              shift_en_i,
  input  logic              err_en_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int SHIFT = VAL_W - 8;
  always_comb begin
    word_o = '0;
    if (shift_en_i) word_o[7:0] = val_i[VAL_W-1:SHIFT];
    else            word_o[VAL_W-1:0] = val_i;
    word_o[WORD_W-1] = err_en_i & err_i;
  end
endmodule

// File: rtl/sq_store.sv
module sq_store
  import sample_queue_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              over_o,
  output logic              under_o,
  input  logic              clr_over_i,
  input  logic              clr_under_i
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [LVL_W-1:0]  cnt_q;
  logic full, empty, do_push, do_pop;

  assign full    = (cnt_q == LVL_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty;
  assign do_push = push_i & (~full | do_pop);
  assign rdata_o = empty ? '0 : mem_q[rptr_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0; rptr_q <= '0; cnt_q <= '0;
      over_o <= 1'b0; under_o <= 1'b0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      if (do_push & ~do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop & ~do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i & ~do_push)     over_o <= 1'b1;
      else if (clr_over_i)       over_o <= 1'b0;
      if (pop_i & empty)         under_o <= 1'b1;
      else if (clr_under_i)      under_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  assert_level_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LVL_W'(DEPTH));
  assert_full_push_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full & push_i & ~pop_i) |=> over_o && $stable(cnt_q));
  assert_swap_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full & push_i & pop_i & ~over_o & ~clr_over_i) |=> (cnt_q == LVL_W'(DEPTH)) && !over_o);
  assert_empty_pop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty & pop_i) |=> under_o);
endmodule

// File: rtl/sq_irq.sv
module sq_irq
  import sample_queue_pkg::*;
(
  input  logic [LVL_W-1:0] level_i,
  input  logic [3:0]       thr_i,
  input  logic             req_en_i,
  input  logic             int_en_i,
  input  logic             int_force_i,
  output logic             raw_o,
  output logic             dreq_o,
  output logic             irq_o
);
  always_comb begin
    raw_o  = ({{(8-LVL_W){1'b0}}, level_i} >= {4'd0, thr_i});
    dreq_o = raw_o & req_en_i;
    irq_o  = (raw_o & int_en_i) | int_force_i;
  end
endmodule

// File: rtl/sample_queue.sv
module sample_queue
  import sample_queue_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [11:0]       res_val_i,
  input  logic              res_err_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_wdata_i,
  input  logic              thr_we_i,
  input  logic [3:0]        thr_wdata_i,
  input  logic              int_we_i,
  input  logic [1:0]        int_wdata_i,
  input  logic              flag_clr_i,
  input  logic [1:0]        flag_clr_mask_i,
  input  logic              rd_i,
  output logic [15:0]       rd_data_o,
  output logic [2:0]        level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              over_o,
  output logic              under_o,
  output logic              dreq_o,
  output logic              irq_raw_o,
  output logic              irq_o
);
  cfg_t       cfg_q;
  logic [3:0] thr_q;
  logic       int_en_q, int_force_q;
  logic [WORD_W-1:0] fmt_word;
  logic [LVL_W-1:0]  lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0; thr_q <= '0; int_en_q <= 1'b0; int_force_q <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
      if (thr_we_i) thr_q <= thr_wdata_i;
      if (int_we_i) {int_force_q, int_en_q} <= int_wdata_i;
    end
  end

  sq_format u_fmt (
    .val_i(res_val_i), .err_i(res_err_i),
    .shift_en_i(cfg_q.shift_en), .err_en_i(cfg_q.err_en),
    .word_o(fmt_word));

  sq_store u_store (
    .clk_i, .rst_ni,
    .push_i(res_valid_i & cfg_q.q_en), .pop_i(rd_i),
    .wdata_i(fmt_word), .rdata_o(rd_data_o), .level_o(lvl),
    .over_o, .under_o,
    .clr_over_i(flag_clr_i & flag_clr_mask_i[1]),
    .clr_under_i(flag_clr_i & flag_clr_mask_i[0]));

  sq_irq u_irq (
    .level_i(lvl), .thr_i(thr_q), .req_en_i(cfg_q.req_en),
    .int_en_i(int_en_q), .int_force_i(int_force_q),
    .raw_o(irq_raw_o), .dreq_o, .irq_o);

  assign level_o = 3'(lvl);
  assign full_o  = (lvl == LVL_W'(DEPTH));
  assign empty_o = (lvl == '0);

  assert_q_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.q_en & !rd_i) |=> $stable(level_o));
  assert_full_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  assert_dreq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |-> irq_raw_o);
  assert_force_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(int_we_i) && $past(int_wdata_i[1])) |-> irq_o);
endmodule

// File: tb/sim_sample_queue.sv
module sim_sample_queue;
  logic clk = 0, rst_ni = 0;
  always #2.5 clk = ~clk;

  logic res_valid = 0, res_err = 0, cfg_we = 0, thr_we = 0, int_we = 0, fclr = 0, rd = 0;
  logic [11:0] res_val = 0;
  logic [3:0] cfg_wd = 0, thr_wd = 0;
  logic [1:0] int_wd = 0, fmask = 0;
  logic [15:0] rdata;
  logic [2:0] level;
  logic full, empty, over, under, dreq, iraw, irq;

  int n_chk = 0, n_bad = 0;

  sample_queue u0 (
    .clk_i(clk), .rst_ni, .res_valid_i(res_valid), .res_val_i(res_val), .res_err_i(res_err),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .thr_we_i(thr_we), .thr_wdata_i(thr_wd),
    .int_we_i(int_we), .int_wdata_i(int_wd), .flag_clr_i(fclr), .flag_clr_mask_i(fmask),
    .rd_i(rd), .rd_data_o(rdata), .level_o(level), .full_o(full), .empty_o(empty),
    .over_o(over), .under_o(under), .dreq_o(dreq), .irq_raw_o(iraw), .irq_o(irq));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic set_cfg(logic [3:0] v); cfg_we = 1; cfg_wd = v; tick; cfg_we = 0; endtask
  task automatic set_thr(logic [3:0] v); thr_we = 1; thr_wd = v; tick; thr_we = 0; endtask
  task automatic set_int(logic [1:0] v); int_we = 1; int_wd = v; tick; int_we = 0; endtask
  task automatic push(logic [11:0] v, logic e);
    res_valid = 1; res_val = v; res_err = e; tick; res_valid = 0;
  endtask
  task automatic pop(output logic [15:0] d); rd = 1; #1; d = rdata; tick; rd = 0; endtask
  task automatic clr(logic [1:0] m); fclr = 1; fmask = m; tick; fclr = 0; endtask

  function automatic int fmt(logic [11:0] v, logic e, logic sh, logic ee);
    int w;
    w = sh ? int'(v) >> 4 : int'(v);
    if (ee && e) w |= 32'h8000;
    return w;
  endfunction

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [11:0] vals[4];
    logic errs[4];
    repeat (3) tick;
    #1;
    chk("R11 level", level, 0); chk("R11 empty", empty, 1); chk("R11 full", full, 0);
    chk("R11 over", over, 0); chk("R11 under", under, 0); chk("R11 irq", irq, 0);
    rst_ni = 1; tick;

    // R1 disabled queue ignores pulses
    push(12'hABC, 0); chk("R1 disabled level", level, 0); chk("R1 disabled empty", empty, 1);

    // R3/R4 format sweep over modes
    for (int m = 0; m < 4; m++) begin
      logic sh, ee;
      sh = m[0]; ee = m[1];
      set_cfg({1'b0, ee, sh, 1'b1});
      for (int k = 0; k < 4; k++) begin
        vals[k] = 12'(32'h5A3 * (k + 1) + m * 16'h1F1);
        errs[k] = k[0];
        push(vals[k], errs[k]);
        chk("R1 level per push", level, k + 1);
      end
      chk("R5 full", full, 1);
      for (int k = 0; k < 4; k++) begin
        pop(d);
        chk(sh ? "R3 R4 shifted word" : "R3 R4 plain word", d, fmt(vals[k], errs[k], sh, ee));
        chk("R2 level after pop", level, 3 - k);
      end
      chk("R5 empty", empty, 1);
    end

    // R6 overflow and simultaneous push/pop
    set_cfg(4'b0001);
    for (int k = 0; k < 4; k++) push(12'(k + 1), 0);
    push(12'h777, 0);
    chk("R6 overflow set", over, 1); chk("R6 level held", level, 4);
    clr(2'b10); chk("R8 over cleared", over, 0);
    res_valid = 1; res_val = 12'h055; rd = 1; #1;
    chk("R2 swap read oldest", rdata, 1);
    tick; res_valid = 0; rd = 0;
    chk("R6 swap no overflow", over, 0); chk("R6 swap level", level, 4);
    for (int k = 0; k < 3; k++) begin pop(d); chk("R2 order after swap", d, k + 2); end
    pop(d); chk("R6 swap entry", d, 12'h055);

    // R7 underflow
    pop(d); chk("R7 empty read zero", d, 0); chk("R7 underflow", under, 1);
    push(12'h1, 0); // creates over? no, empty now
    clr(2'b10); chk("R8 under kept", under, 1);
    clr(2'b01); chk("R8 under cleared", under, 0);
    pop(d);

    // R9/R10 threshold sweep
    for (int t = 0; t < 16; t++) begin
      set_thr(4'(t));
      for (int l = 0; l <= 4; l++) begin
        for (int c = 0; c < 8; c++) begin
          set_cfg({c[0], 3'b001}); set_int(c[2:1]);
          #1;
          chk("R9 raw", iraw, int'(l >= t));
          chk("R9 dreq", dreq, int'(l >= t) & c[0]);
          chk("R10 irq", irq, (int'(l >= t) & c[1]) | c[2]);
        end
        if (l < 4) push(12'h3, 0);
      end
      for (int k = 0; k < 4; k++) pop(d);
      chk("R5 drained", level, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule